// File: doc/BRIEF.md
# Bridge Command Packet Reassembler

This block sits behind a USB endpoint on the device side of a host-to-SPI bridge. It takes host-to-device command packets as a byte stream, where each packet is framed by a first-byte marker and a last-byte marker. It decodes the 16-bit packet identifier and acts on five commands: configuration query, transfer start, transfer continue, response restart and chip select. Any other identifier is reported back as unexpected.

For a transfer, the block stores the write payload in a local byte buffer. It validates the write and read counts against the buffer size. It also checks that each continuation packet picks up exactly at the number of write bytes already received. Once the last write byte has arrived, it raises a transfer event that carries the write count and the effective read count. The SPI engine can then read the stored bytes through a combinational read port. A protocol failure produces a status event with a specific 16-bit code instead of a transfer event.

Both stream edges use valid/ready. Input bytes are accepted only on cycles where `in_valid` and `in_ready` are both high. At most one event is ever pending. While an event waits for `evt_ready`, `in_ready` stays low and the event fields do not change, so the next packet is held back until the event is consumed.

Top module: `spi_bridge_cmd_rx`

## Requirements
- R1: The result of a packet is presented on the event port in the cycle after its `in_last` byte is accepted, with `evt_valid` high. The event fields hold still and `in_ready` stays low until `evt_ready` is seen high with `evt_valid`. Event kind codes are: 0 configuration, 1 transfer, 2 status, 3 restart, 4 chip select.
- R2: The packet identifier is the first two bytes, little-endian. Identifier 0 yields event kind 0 and identifier 4 yields event kind 3, whatever the transfer state.
- R3: A transfer start (identifier 2) carries the write count in bytes 2–3 and the read count in bytes 4–5, both little-endian, with write payload from byte 6. Write bytes are stored at buffer addresses 0, 1, 2, ... in arrival order. When a packet ends with every write byte received, a kind-1 event reports both counts. A write count of 0 fires from the start packet itself.
- R4: A transfer continue (identifier 3) carries a data index in bytes 2–3 and payload from byte 4. If the index equals the number of write bytes already received, the payload is appended. Otherwise the packet yields status 0x0006 and the open transfer is dropped.
- R5: A payload byte beyond the write count yields status 0x0007 at packet end and drops the transfer.
- R6: A write count above `BUF_BYTES` yields status 0x0003. Otherwise, an effective read count above `BUF_BYTES` yields status 0x0004. The write count check comes first.
- R7: A read count of 0xFFFF requests full duplex. With `fdx_en` high the reported read count equals the write count. With `fdx_en` low the status is 0x0009, checked after the write count and before the read count.
- R8: With `bridge_en` low, every transfer start yields status 0x0005, ahead of all other count checks.
- R9: Status 0x0008 is given for: a continue with no open transfer; identifiers other than 0, 2, 3, 4 and 7; and a packet that ends before its header is complete (header lengths: identifier 2 bytes, start 6, continue 4, chip select 4).
- R10: A transfer start received while a transfer is open drops the old transfer and begins counting afresh.
- R11: A chip-select packet (identifier 7) with an action field in bytes 2–3 sets `cs_level` to bit 0 of that field and yields a kind-4 event with status 0x0000. A truncated chip-select packet leaves `cs_level` unchanged.
- R12: After reset `in_ready` is high, `evt_valid` is low and `cs_level` is low.
- R13: Bytes offered outside a packet (after a last byte and before the next first byte) are consumed without effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bridge_en | input | 1 | Bridge enabled; low makes transfer starts fail |
| fdx_en | input | 1 | Full-duplex transfers allowed |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can take an input byte |
| in_data | input | 8 | Input byte |
| in_first | input | 1 | Byte is the first of a packet |
| in_last | input | 1 | Byte is the last of a packet |
| evt_valid | output | 1 | Event pending |
| evt_ready | input | 1 | Consumer takes the event |
| evt_kind | output | 3 | Event kind code |
| evt_status | output | 16 | Status code for kinds 2 and 4 |
| evt_wr_count | output | 16 | Write count of a transfer event |
| evt_rd_count | output | 16 | Effective read count of a transfer event |
| cs_level | output | 1 | Chip-select level requested by the host |
| buf_rd_addr | input | $clog2(BUF_BYTES) | Write-buffer read address |
| buf_rd_data | output | 8 | Write-buffer byte at that address |

## Verification
The hardest states to reach from the ports are those between packets of one transfer. Examples are a continuation packet whose index is off by one from the running count, and a fresh start that lands while an earlier transfer is still half filled. The bench reaches them by building continue packets with deliberately wrong offsets, and by cutting transfers short before issuing a new start. It then probes with a further continue to confirm that the earlier transfer is really closed. A sweep over every write count from 0 to two past a small buffer limit, combined with several read counts and both full-duplex settings, splits each transfer across one start packet and several continues. It checks the expected event and the buffer contents arithmetically.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
  // event kinds presented on the event port
  typedef enum logic [2:0] {
    EV_CFG     = 3'd0,
    EV_XFER    = 3'd1,
    EV_STAT    = 3'd2,
    EV_RESTART = 3'd3,
    EV_CS      = 3'd4
  } ev_kind_e;

  // packet identifiers
  localparam logic [15:0] ID_CFG     = 16'd0;
  localparam logic [15:0] ID_START   = 16'd2;
  localparam logic [15:0] ID_CONT    = 16'd3;
  localparam logic [15:0] ID_RESTART = 16'd4;
  localparam logic [15:0] ID_CS      = 16'd7;

  // status codes
  localparam logic [15:0] ST_OK         = 16'h0000;
  localparam logic [15:0] ST_WR_BIG     = 16'h0003;
  localparam logic [15:0] ST_RD_BIG     = 16'h0004;
  localparam logic [15:0] ST_DISABLED   = 16'h0005;
  localparam logic [15:0] ST_BAD_IDX    = 16'h0006;
  localparam logic [15:0] ST_OVERFLOW   = 16'h0007;
  localparam logic [15:0] ST_UNEXPECTED = 16'h0008;
  localparam logic [15:0] ST_NO_FDX     = 16'h0009;

  localparam logic [15:0] FDX_MARK = 16'hFFFF;

  // header layout: identifier plus two 16-bit fields
  localparam int NFIELDS = 3;
  localparam int IDX_W   = $clog2(2 * NFIELDS + 1);
  typedef logic [IDX_W-1:0] idx_t;
  localparam idx_t IDX_ID_HI = idx_t'(1);
  localparam idx_t IDX_F1_HI = idx_t'(3);
  localparam idx_t IDX_F2_HI = idx_t'(5);
  localparam idx_t IDX_CPAY  = idx_t'(4);
  localparam idx_t IDX_SPAY  = idx_t'(2 * NFIELDS);
endpackage

// File: rtl/sbr_field_cap.sv
module sbr_field_cap
  import sbr_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    beat,
  input  logic                    first,
  input  logic                    last,
  input  logic [7:0]              data,
  output idx_t                    idx_eff,
  output logic [NFIELDS-1:0][15:0] fld_now
);
  idx_t idx_q;

  // a first marker always restarts the byte position
  assign idx_eff = first ? '0 : idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (beat) begin
      if (last)                  idx_q <= '0;
      else if (idx_eff == IDX_SPAY) idx_q <= IDX_SPAY;
      else                       idx_q <= idx_eff + idx_t'(1);
    end
  end

  for (genvar f = 0; f < NFIELDS; f++) begin : g_fld
    logic [15:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q <= '0;
      end else if (beat) begin
        if (idx_eff == idx_t'(2 * f))     q[7:0]  <= data;
        if (idx_eff == idx_t'(2 * f + 1)) q[15:8] <= data;
      end
    end
    // value including the byte on the wire when it completes the field
    assign fld_now[f] = (idx_eff == idx_t'(2 * f + 1)) ? {data, q[7:0]} : q;
  end
endmodule

// File: rtl/sbr_start_check.sv
module sbr_start_check
  import sbr_pkg::*;
#(
  parameter int LIMIT = 298
) (
  input  logic        enable,
  input  logic        fdx_allowed,
  input  logic [15:0] wr_count,
  input  logic [15:0] rd_count,
  output logic [15:0] code,
  output logic [15:0] rd_eff
);
  always_comb begin
    rd_eff = (rd_count == FDX_MARK) ? wr_count : rd_count;
    if (!enable)                                  code = ST_DISABLED;
    else if (32'(wr_count) > LIMIT)               code = ST_WR_BIG;
    else if (rd_count == FDX_MARK && !fdx_allowed) code = ST_NO_FDX;
    else if (32'(rd_eff) > LIMIT)                 code = ST_RD_BIG;
    else                                          code = ST_OK;
  end
endmodule

// File: rtl/sbr_wbuf.sv
module sbr_wbuf #(
  parameter int DEPTH = 298,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = (32'(raddr) < DEPTH) ? mem[raddr] : 8'h00;
endmodule

// File: rtl/spi_bridge_cmd_rx.sv
module spi_bridge_cmd_rx
  import sbr_pkg::*;
#(
  parameter int BUF_BYTES = 298,
  localparam int AW = $clog2(BUF_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bridge_en,
  input  logic          fdx_en,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_data,
  input  logic          in_first,
  input  logic          in_last,
  output logic          evt_valid,
  input  logic          evt_ready,
  output logic [2:0]    evt_kind,
  output logic [15:0]   evt_status,
  output logic [15:0]   evt_wr_count,
  output logic [15:0]   evt_rd_count,
  output logic          cs_level,
  input  logic [AW-1:0] buf_rd_addr,
  output logic [7:0]    buf_rd_data
);
  // registered state
  logic        in_pkt_q, coll_q, cs_q, ev_q;
  logic [15:0] rx_q, wcnt_q, rcnt_q, code_q;
  ev_kind_e    ev_kind_q;
  logic [15:0] ev_stat_q, ev_wr_q, ev_rd_q;

  // decode signals
  logic                     beat;
  idx_t                     idx;
  logic [NFIELDS-1:0][15:0] fld;
  logic [15:0]              id_w, f1_w, f2_w;
  logic [15:0]              chk_code, chk_rd;
  logic                     is_start, is_cont, payload;

  // next-state values
  logic        coll_nx, cs_nx, wr_en, fire;
  logic [15:0] rx_nx, wcnt_nx, rcnt_nx, code_nx, stat_nx;
  ev_kind_e    kind_nx;

  assign in_ready = !ev_q;
  assign beat     = in_valid && in_ready && (in_pkt_q || in_first);

  sbr_field_cap u_fields (
    .clk     (clk),
    .rst_n   (rst_n),
    .beat    (beat),
    .first   (in_first),
    .last    (in_last),
    .data    (in_data),
    .idx_eff (idx),
    .fld_now (fld)
  );

  assign id_w = fld[0];
  assign f1_w = fld[1];
  assign f2_w = fld[2];

  sbr_start_check #(.LIMIT(BUF_BYTES)) u_check (
    .enable      (bridge_en),
    .fdx_allowed (fdx_en),
    .wr_count    (f1_w),
    .rd_count    (f2_w),
    .code        (chk_code),
    .rd_eff      (chk_rd)
  );

  sbr_wbuf #(.DEPTH(BUF_BYTES)) u_buf (
    .clk   (clk),
    .we    (wr_en),
    .waddr (rx_q[AW-1:0]),
    .wdata (in_data),
    .raddr (buf_rd_addr),
    .rdata (buf_rd_data)
  );

  assign is_start = (id_w == ID_START);
  assign is_cont  = (id_w == ID_CONT);
  assign payload  = (is_start && idx == IDX_SPAY) || (is_cont && idx >= IDX_CPAY);

  always_comb begin
    coll_nx = coll_q;
    rx_nx   = rx_q;
    wcnt_nx = wcnt_q;
    rcnt_nx = rcnt_q;
    code_nx = in_first ? ST_OK : code_q;
    cs_nx   = cs_q;
    wr_en   = 1'b0;
    fire    = 1'b0;
    kind_nx = EV_STAT;
    stat_nx = ST_OK;
    if (beat) begin
      // identifier complete: a start drops any open transfer
      if (idx == IDX_ID_HI && is_start) begin
        coll_nx = 1'b0;
        rx_nx   = '0;
      end
      if (idx == IDX_ID_HI && is_cont && !coll_q) code_nx = ST_UNEXPECTED;
      // continuation offset must match running count
      if (idx == IDX_F1_HI && is_cont && code_nx == ST_OK && coll_q && f1_w != rx_q) begin
        code_nx = ST_BAD_IDX;
        coll_nx = 1'b0;
      end
      // start header complete: validate counts
      if (idx == IDX_F2_HI && is_start && code_nx == ST_OK) begin
        if (chk_code != ST_OK) begin
          code_nx = chk_code;
        end else begin
          coll_nx = 1'b1;
          wcnt_nx = f1_w;
          rcnt_nx = chk_rd;
        end
      end
      // payload byte
      if (payload && code_nx == ST_OK && coll_q) begin
        if (rx_q == wcnt_q) begin
          code_nx = ST_OVERFLOW;
          coll_nx = 1'b0;
        end else begin
          wr_en = 1'b1;
          rx_nx = rx_q + 16'd1;
        end
      end
      // packet end: decide the event
      if (in_last) begin
        fire = 1'b1;
        if (idx == '0) begin
          stat_nx = ST_UNEXPECTED;
        end else begin
          case (id_w)
            ID_CFG:     kind_nx = EV_CFG;
            ID_RESTART: kind_nx = EV_RESTART;
            ID_CS: begin
              if (idx >= IDX_F1_HI) begin
                kind_nx = EV_CS;
                cs_nx   = f1_w[0];
              end else begin
                stat_nx = ST_UNEXPECTED;
              end
            end
            ID_START, ID_CONT: begin
              if (idx < (is_start ? IDX_F2_HI : IDX_F1_HI)) begin
                stat_nx = ST_UNEXPECTED;
                coll_nx = 1'b0;
              end else if (code_nx != ST_OK) begin
                stat_nx = code_nx;
              end else if (coll_nx && rx_nx == wcnt_nx) begin
                kind_nx = EV_XFER;
                coll_nx = 1'b0;
              end else begin
                fire = 1'b0;
              end
            end
            default: stat_nx = ST_UNEXPECTED;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_pkt_q  <= 1'b0;
      coll_q    <= 1'b0;
      cs_q      <= 1'b0;
      rx_q      <= '0;
      wcnt_q    <= '0;
      rcnt_q    <= '0;
      code_q    <= ST_OK;
      ev_q      <= 1'b0;
      ev_kind_q <= EV_CFG;
      ev_stat_q <= '0;
      ev_wr_q   <= '0;
      ev_rd_q   <= '0;
    end else begin
      if (beat) begin
        in_pkt_q <= !in_last;
        coll_q   <= coll_nx;
        rx_q     <= rx_nx;
        wcnt_q   <= wcnt_nx;
        rcnt_q   <= rcnt_nx;
        code_q   <= in_last ? ST_OK : code_nx;
        cs_q     <= cs_nx;
      end
      if (fire) begin
        ev_q      <= 1'b1;
        ev_kind_q <= kind_nx;
        ev_stat_q <= stat_nx;
        ev_wr_q   <= (kind_nx == EV_XFER) ? wcnt_nx : 16'd0;
        ev_rd_q   <= (kind_nx == EV_XFER) ? rcnt_nx : 16'd0;
      end else if (evt_ready) begin
        ev_q <= 1'b0;
      end
    end
  end

  assign evt_valid    = ev_q;
  assign evt_kind     = ev_kind_q;
  assign evt_status   = ev_stat_q;
  assign evt_wr_count = ev_wr_q;
  assign evt_rd_count = ev_rd_q;
  assign cs_level     = cs_q;
endmodule

// File: rtl/sbr_chk.sv
module sbr_chk #(
  parameter int LIMIT = 298
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        in_last,
  input logic        evt_valid,
  input logic        evt_ready,
  input logic [2:0]  evt_kind,
  input logic [15:0] evt_status,
  input logic [15:0] evt_wr_count,
  input logic [15:0] evt_rd_count,
  input logic        cs_level
);
  AST_EVT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && !evt_ready |=> evt_valid && $stable(evt_kind) && $stable(evt_status)
      && $stable(evt_wr_count) && $stable(evt_rd_count)); // R1

  AST_EVT_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_valid) |-> $past(in_valid && in_ready && in_last)); // R1

  AST_XFER_IN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && evt_kind == 3'd1 |-> 32'(evt_wr_count) <= LIMIT
      && 32'(evt_rd_count) <= LIMIT); // R6

  AST_STAT_IS_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && evt_kind == 3'd2 |-> evt_status >= 16'd3 && evt_status <= 16'd9); // R9

  AST_CS_WITH_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cs_level) |-> evt_valid && evt_kind == 3'd4 && evt_status == 16'd0); // R11
endmodule

bind spi_bridge_cmd_rx sbr_chk #(.LIMIT(BUF_BYTES)) u_sbr_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .in_last      (in_last),
  .evt_valid    (evt_valid),
  .evt_ready    (evt_ready),
  .evt_kind     (evt_kind),
  .evt_status   (evt_status),
  .evt_wr_count (evt_wr_count),
  .evt_rd_count (evt_rd_count),
  .cs_level     (cs_level)
);

// File: tb/spi_bridge_cmd_rx_tb_top.sv
module spi_bridge_cmd_rx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LIM = 20;
  localparam int AW = $clog2(LIM);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bridge_en = 1'b1, fdx_en = 1'b1;
  logic          in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0;
  logic [7:0]    in_data = 8'h00;
  logic          in_ready, evt_valid, cs_level;
  logic          evt_ready = 1'b0;
  logic [2:0]    evt_kind;
  logic [15:0]   evt_status, evt_wr_count, evt_rd_count;
  logic [AW-1:0] buf_rd_addr = '0;
  logic [7:0]    buf_rd_data;

  spi_bridge_cmd_rx #(.BUF_BYTES(LIM)) dut_i (
    .clk(clk), .rst_n(rst_n), .bridge_en(bridge_en), .fdx_en(fdx_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_first(in_first), .in_last(in_last),
    .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_kind(evt_kind),
    .evt_status(evt_status), .evt_wr_count(evt_wr_count),
    .evt_rd_count(evt_rd_count), .cs_level(cs_level),
    .buf_rd_addr(buf_rd_addr), .buf_rd_data(buf_rd_data)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [7:0] pk [0:79];
  int plen = 0;

  function automatic logic [7:0] pat(int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic put16(input int pos, input logic [15:0] v);
    pk[pos] = v[7:0];
    pk[pos + 1] = v[15:8];
  endtask

  task automatic send_pkt();
    for (int i = 0; i < plen; i++) begin
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1;
      in_data  = pk[i];
      in_first = (i == 0);
      in_last  = (i == plen - 1);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_first = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic mk_start(input logic [15:0] wc, input logic [15:0] rc, input int n);
    put16(0, 16'd2);
    put16(2, wc);
    put16(4, rc);
    for (int i = 0; i < n; i++) pk[6 + i] = pat(i);
    plen = 6 + n;
  endtask

  task automatic mk_cont(input int off, input int n);
    put16(0, 16'd3);
    put16(2, 16'(off));
    for (int i = 0; i < n; i++) pk[4 + i] = pat(off + i);
    plen = 4 + n;
  endtask

  task automatic mk_id(input logic [15:0] id);
    put16(0, id);
    plen = 2;
  endtask

  task automatic expect_evt(input logic [2:0] k, input logic [15:0] s,
                            input logic [15:0] w, input logic [15:0] r,
                            input string req, input string what);
    logic [63:0] act;
    for (int t = 0; t < 10 && !evt_valid; t++) @(negedge clk);
    if (evt_valid) act = {13'd0, evt_kind, evt_status, evt_wr_count, evt_rd_count};
    else act = '1;
    chk(act == {13'd0, k, s, w, r}, req, what, act, {13'd0, k, s, w, r});
    if (evt_valid) begin
      evt_ready = 1'b1;
      @(negedge clk);
      evt_ready = 1'b0;
    end
  endtask

  task automatic expect_none(input string req, input string what);
    repeat (3) @(negedge clk);
    chk(!evt_valid, req, what, 64'(evt_valid), 64'd0);
  endtask

  task automatic check_buf(input int n, input string req);
    int errs = 0;
    for (int i = 0; i < n; i++) begin
      buf_rd_addr = AW'(i);
      #1;
      if (buf_rd_data != pat(i)) errs++;
    end
    chk(errs == 0, req, "buffer content mismatches", 64'(errs), 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(in_ready && !evt_valid && !cs_level, "R12", "reset state",
        {61'd0, in_ready, evt_valid, cs_level}, 64'd4);

    // R13 stray bytes outside a packet
    for (int i = 0; i < 3; i++) begin
      in_valid = 1'b1; in_data = 8'h02; in_first = 1'b0; in_last = (i == 2);
      @(negedge clk);
    end
    in_valid = 1'b0; in_last = 1'b0;
    expect_none("R13", "stray bytes");

    // R2 config and restart
    mk_id(16'd0); send_pkt();
    expect_evt(3'd0, 16'd0, 16'd0, 16'd0, "R2", "config query");
    mk_id(16'd4); send_pkt();
    expect_evt(3'd3, 16'd0, 16'd0, 16'd0, "R2", "restart");
    mk_id(16'h0100); send_pkt();
    expect_evt(3'd2, 16'd8, 16'd0, 16'd0, "R2", "identifier byte order");

    // R9 unexpected identifiers and truncation
    foreach (pk[j]) pk[j] = 8'h00;
    for (int id = 1; id <= 9; id++) begin
      if (id == 1 || id == 5 || id == 6 || id == 8 || id == 9) begin
        mk_id(16'(id)); send_pkt();
        expect_evt(3'd2, 16'd8, 16'd0, 16'd0, "R9", "unsupported identifier");
      end
    end
    pk[0] = 8'h00; plen = 1; send_pkt();
    expect_evt(3'd2, 16'd8, 16'd0, 16'd0, "R9", "one-byte packet");
    mk_start(16'd3, 16'd0, 0); plen = 4; send_pkt();
    expect_evt(3'd2, 16'd8, 16'd0, 16'd0, "R9", "truncated start");
    mk_cont(0, 2); send_pkt();
    expect_evt(3'd2, 16'd8, 16'd0, 16'd0, "R9", "continue with no transfer");

    // R1 back-pressure on the event port
    mk_start(16'd0, 16'd5, 0); send_pkt();
    begin
      int held = 0;
      for (int t = 0; t < 5; t++) begin
        if (evt_valid && !in_ready && evt_kind == 3'd1) held++;
        @(negedge clk);
      end
      chk(held == 5, "R1", "event held under back-pressure", 64'(held), 64'd5);
    end
    expect_evt(3'd1, 16'd0, 16'd0, 16'd5, "R3", "zero write count fires from start");

    // R4 good continuation and wrong index
    mk_start(16'd6, 16'd1, 2); send_pkt();
    expect_none("R4", "partial transfer pending");
    mk_cont(2, 4); send_pkt();
    expect_evt(3'd1, 16'd0, 16'd6, 16'd1, "R4", "continuation completes");
    check_buf(6, "R4");
    mk_start(16'd8, 16'd0, 3); send_pkt();
    mk_cont(2, 2); send_pkt();
    expect_evt(3'd2, 16'd6, 16'd0, 16'd0, "R4", "wrong data index");
    mk_cont(3, 2); send_pkt();
    expect_evt(3'd2, 16'd8, 16'd0, 16'd0, "R4", "transfer dropped after bad index");

    // R5 overflow in start and in continue
    mk_start(16'd2, 16'd0, 3); send_pkt();
    expect_evt(3'd2, 16'd7, 16'd0, 16'd0, "R5", "overflow in start");
    mk_start(16'd4, 16'd0, 2); send_pkt();
    mk_cont(2, 3); send_pkt();
    expect_evt(3'd2, 16'd7, 16'd0, 16'd0, "R5", "overflow in continue");

    // R10 restart of a transfer
    mk_start(16'd10, 16'd0, 4); send_pkt();
    mk_start(16'd3, 16'd2, 3); send_pkt();
    expect_evt(3'd1, 16'd0, 16'd3, 16'd2, "R10", "new start replaces old");
    mk_cont(4, 1); send_pkt();
    expect_evt(3'd2, 16'd8, 16'd0, 16'd0, "R10", "old transfer gone");

    // R8 bridge disabled
    bridge_en = 1'b0;
    mk_start(16'd3, 16'd0, 3); send_pkt();
    expect_evt(3'd2, 16'd5, 16'd0, 16'd0, "R8", "disabled small");
    mk_start(16'(LIM + 5), 16'hFFFF, 0); send_pkt();
    expect_evt(3'd2, 16'd5, 16'd0, 16'd0, "R8", "disabled priority");
    bridge_en = 1'b1;

    // R11 chip select
    put16(0, 16'd7); put16(2, 16'd1); plen = 4; send_pkt();
    expect_evt(3'd4, 16'd0, 16'd0, 16'd0, "R11", "assert select");
    chk(cs_level == 1'b1, "R11", "level after assert", 64'(cs_level), 64'd1);
    put16(0, 16'd7); put16(2, 16'd0); plen = 4; send_pkt();
    expect_evt(3'd4, 16'd0, 16'd0, 16'd0, "R11", "release select");
    chk(cs_level == 1'b0, "R11", "level after release", 64'(cs_level), 64'd0);
    put16(0, 16'd7); put16(2, 16'd1); plen = 3; send_pkt();
    expect_evt(3'd2, 16'd8, 16'd0, 16'd0, "R11", "truncated select");
    chk(cs_level == 1'b0, "R11", "level after truncated", 64'(cs_level), 64'd0);

    // R3 R6 R7 sweep over write counts and read counts
    for (int wc = 0; wc <= LIM + 2; wc++) begin
      for (int rs = 0; rs < 6; rs++) begin
        logic [15:0] rc, rde, es;
        int nfirst, off, n;
        string req;
        rc = (rs == 0) ? 16'd0 : (rs == 1) ? 16'd7 : (rs == 2) ? 16'(LIM) :
             (rs == 3) ? 16'(LIM + 1) : 16'hFFFF;
        fdx_en = (rs != 5);
        rde = (rc == 16'hFFFF) ? 16'(wc) : rc;
        if (wc > LIM) begin es = 16'd3; req = "R6"; end
        else if (rc == 16'hFFFF && !fdx_en) begin es = 16'd9; req = "R7"; end
        else if (32'(rde) > LIM) begin es = 16'd4; req = "R6"; end
        else begin es = 16'd0; req = (rc == 16'hFFFF) ? "R7" : "R3"; end
        nfirst = (wc < 5) ? wc : 5;
        mk_start(16'(wc), rc, nfirst); send_pkt();
        if (es == 16'd0) begin
          off = nfirst;
          while (off < wc) begin
            n = (wc - off < 7) ? wc - off : 7;
            mk_cont(off, n); send_pkt();
            off += n;
          end
          expect_evt(3'd1, 16'd0, 16'(wc), rde, req, "sweep transfer");
          check_buf(wc, "R3");
        end else begin
          expect_evt(3'd2, es, 16'd0, 16'd0, req, "sweep rejection");
        end
      end
    end
    fdx_en = 1'b1;

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule